// File: doc/BRIEF.md
# Keyed Watchdog Enable Counter

This block is a watchdog counter whose software enable is guarded by a 4-bit key. A static hardware-enable input forces the watchdog on. When that input is low, software controls the watchdog through a 4-bit field that it writes over a simple register write port. Only one exact key value, 1010b, switches the watchdog off, and any other value switches it on. The field returns to the off key at reset.

While the watchdog is active, a free-running counter advances once per clock. When the counter reaches the parameterised timeout it emits a one-cycle reset request and starts again from zero. A kick strobe from the instruction decoder clears the counter while the watchdog is active and has no effect while it is off. A read-back port returns the stored field and the active flag.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the key field reads 1010b, the active flag is low and no reset request is asserted.
- R2: While hw_en is high the watchdog is active, whatever value the key field holds.
- R3: While hw_en is low the watchdog is inactive only when the key field equals 1010b. Every other value, including the recommended 0101b, makes it active.
- R4: A write (wr_en high) stores wr_data[3:0] into the key field on the next clock edge, and rd_key returns the stored field.
- R5: While the watchdog is active the counter advances by one per clock. After TIMEOUT active cycles with no kick, rst_req goes high for exactly one cycle and counting restarts from zero.
- R6: A kick while the watchdog is active returns the counter to zero, so the next rst_req comes TIMEOUT cycles after the kick.
- R7: While the watchdog is inactive the counter holds at zero, rst_req stays low and kicks have no effect. When the watchdog becomes active it counts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Static hardware enable that forces the watchdog on |
| wr_en | input | 1 | Write strobe for the key field |
| wr_data | input | 4 | Key value to write |
| kick | input | 1 | Clear strobe for the counter |
| rd_key | output | 4 | Stored key field |
| active | output | 1 | Watchdog active flag |
| rst_req | output | 1 | One-cycle reset request on overflow |

## Verification
The enable decode is tried with the off key, the recommended on key, near-miss keys that differ from the off key in a single bit, and all-zero and all-one values, each with hw_en both low and high. These cases separate an exact-match decode from a partial or inverted one. Timeout tests measure the exact cycle of rst_req with and without kicks, which separates a correct kick from an ignored one and catches an off-by-one terminal count. Kicks and long idle periods while the watchdog is off show that the inactive state neither counts nor reacts to kicks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int KEY_W = 4;
    typedef logic [KEY_W-1:0] key_t;
    localparam key_t KEY_OFF = 4'b1010;
    localparam key_t KEY_ON  = 4'b0101;

    typedef struct packed {
        logic hw_en;
        key_t key;
    } en_cfg_t;

    function automatic logic wd_active(en_cfg_t c);
        return c.hw_en || (c.key != KEY_OFF);
    endfunction
endpackage

// File: rtl/wdog_keyreg.sv
module wdog_keyreg
    import wdog_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  key_t wr_data,
    output key_t key
);
    always_ff @(posedge clk) begin
        if (rst)        key <= KEY_OFF;
        else if (wr_en) key <= wr_data;
    end

    a_r1_key_reset: assert property (@(posedge clk) rst |=> key == KEY_OFF);
    a_r4_key_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> key == $past(wr_data));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int TIMEOUT = 16,
    localparam int CW = $clog2(TIMEOUT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic ovf
);
    logic [CW-1:0] cnt;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (!run || kick) cnt <= '0;
            else if (cnt == LAST) begin
                cnt <= '0;
                ovf <= 1'b1;
            end else cnt <= cnt + 1'b1;
        end
    end

    a_r5_pulse: assert property (@(posedge clk) disable iff (rst) ovf |=> !ovf);
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
    a_r6_kick_clear: assert property (@(posedge clk) disable iff (rst)
        (run && kick) |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_en,
    input  logic       wr_en,
    input  logic [3:0] wr_data,
    input  logic       kick,
    output logic [3:0] rd_key,
    output logic       active,
    output logic       rst_req
);
    key_t    key;
    en_cfg_t cfg;

    wdog_keyreg u_key (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .key(key)
    );

    always_comb begin
        cfg.hw_en = hw_en;
        cfg.key   = key;
    end

    assign active = wd_active(cfg);
    assign rd_key = key;

    wdog_counter #(.TIMEOUT(TIMEOUT)) u_cnt (
        .clk(clk), .rst(rst), .run(active), .kick(kick), .ovf(rst_req)
    );

    a_r2_hw_force: assert property (@(posedge clk) disable iff (rst)
        hw_en |-> active);
    a_r3_key_off: assert property (@(posedge clk) disable iff (rst)
        (!hw_en && rd_key == 4'b1010) |-> !active);
    a_r7_no_req_idle: assert property (@(posedge clk) disable iff (rst)
        !$past(active) |-> !rst_req);
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
    localparam int TO = 16;
    logic clk = 0, rst = 1, hw_en = 0, wr_en = 0, kick = 0;
    logic [3:0] wr_data = 0;
    logic [3:0] rd_key;
    logic active, rst_req;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    wdog_keyed #(.TIMEOUT(TO)) uut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(); @(posedge clk); #1; endtask

    task automatic wr(logic [3:0] v);
        wr_en = 1; wr_data = v; step(); wr_en = 0;
    endtask

    // counts cycles until rst_req, up to lim; returns lim+1 if none
    task automatic wait_req(int lim, output int n);
        n = lim + 1;
        for (int i = 1; i <= lim; i++) begin
            step();
            if (rst_req) begin n = i; break; end
        end
    endtask

    task automatic t_reset();
        chk("R1 key", rd_key, 4'b1010);
        chk("R1 active", active, 0);
        chk("R1 req", rst_req, 0);
    endtask

    task automatic t_decode();
        logic [3:0] v [6] = '{4'b1010, 4'b0101, 4'b1011, 4'b1000, 4'b0000, 4'b1111};
        for (int i = 0; i < 6; i++) begin
            wr(v[i]);
            chk("R4 readback", rd_key, v[i]);
            hw_en = 0; #1;
            chk("R3 decode", active, v[i] != 4'b1010);
            hw_en = 1; #1;
            chk("R2 hw force", active, 1);
            hw_en = 0;
        end
        wr(4'b1010);
    endtask

    task automatic t_timeout();
        int n, m;
        wr(4'b0101);   // active from this edge; counter starts at zero
        wait_req(3*TO, n);
        chk("R5 first timeout", n, TO);
        step(); chk("R5 single pulse", rst_req, 0);
        wait_req(3*TO, m);
        chk("R5 restart", m + 1, TO);
    endtask

    task automatic t_kick();
        int n;
        repeat (5) step();
        kick = 1; step(); kick = 0;
        wait_req(3*TO, n);
        chk("R6 kick delay", n, TO);
    endtask

    task automatic t_idle();
        int n;
        wr(4'b1010);
        chk("R7 off", active, 0);
        kick = 1; step(); kick = 0;
        wait_req(3*TO, n);
        chk("R7 no req while off", n, 3*TO + 1);
        hw_en = 1; // becomes active now; first edge counts from zero
        wait_req(3*TO, n);
        chk("R7 fresh start", n, TO);
        hw_en = 0;
        step();
        chk("R7 off again", active, 0);
    endtask

    initial begin
        #50000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(); step(); rst = 0; #1;
        t_reset();
        t_decode();
        t_timeout();
        t_kick();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule